// File: doc/BRIEF.md
# Zero-Page Bidirectional Peripheral Port

This block is a byte-wide general purpose port that lives inside a processor's own address space. It watches the CPU bus (address, write data, read/not-write strobe) and answers only two fixed addresses at the bottom of page zero. Address 0x0000 holds a direction mask and address 0x0001 holds a latch of output values. Every pad bit is independently steered. A direction bit of 1 drives the pad from the matching latch bit. A direction bit of 0 leaves the pad undriven and treats it as an input.

When the CPU reads either address, the block raises a select line so that the bus takes the port's read data instead of external memory. A read of 0x0001 merges two sources. Bits set as outputs return the latch contents. Bits set as inputs return the pad level, after it has passed through a two-flop synchronizer. An outside device can therefore change what 0x0001 reads back. Both locations are in page zero, so short zero-page and zero-page-indirect accesses reach them.

The reset input is asserted asynchronously and released synchronously by an internal reset synchronizer.

Top module: `zp_io_port`

## Requirements
- R1: While reset is asserted, and after it is released, the direction mask and the output latch are both 0x00, so `pad_oe` and `pad_out` are 0x00 and every pad is an input.
- R2: A bus write (`cpu_rnw`=0) to address 0x0000 loads `cpu_wdata` into the direction mask on that clock edge. `pad_oe` shows the new mask after that edge.
- R3: A bus write to address 0x0001 loads `cpu_wdata` into the output latch on that clock edge. `pad_out` shows the new latch value after that edge.
- R4: While `cpu_addr` is 0x0000, `cpu_rdata` equals the direction mask.
- R5: While `cpu_addr` is 0x0001, each bit of `cpu_rdata` whose direction bit is 1 equals the output latch bit. Each bit whose direction bit is 0 equals the synchronized pad input bit.
- R6: A change on `pad_in` reaches `cpu_rdata` after exactly two rising clock edges. After one edge the old level is still returned.
- R7: `port_sel` is 1 exactly when all 16 bits of `cpu_addr` equal 0x0000 or 0x0001, whatever the value of `cpu_rnw`. While `port_sel` is 0, `cpu_rdata` is 0x00.
- R8: Writes to any other address, including aliases that differ only in the upper byte such as 0x0101 and 0xFF00, change neither register.
- R9: A read cycle (`cpu_rnw`=1) at 0x0000 or 0x0001 leaves both registers unchanged, whatever value is on `cpu_wdata`.
- R10: The output latch keeps its contents while the matching bits are set as inputs. When a bit is later turned into an output, it drives the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_rdata | output | 8 | Port read data, valid when port_sel is 1 |
| port_sel | output | 1 | Port claims this address; bus must use cpu_rdata |
| pad_out | output | 8 | Per-pin output value |
| pad_oe | output | 8 | Per-pin output enable, 1 = driven |
| pad_in | input | 8 | Per-pin input level, asynchronous |

## Verification
The bench builds the port with its default parameters: an 8-bit port, a 16-bit address, the mask at 0x0000, the latch at 0x0001, and two synchronizer stages. Because the decode covers the full 16-bit address, writes to aliases such as 0x0101 and 0xFF00 can be shown to be ignored. With only two stages, the input latency can be counted edge by edge, which separates the one-edge state from the two-edge state. The byte width allows mixed direction masks such as 0xF0 and 0x0F, where latch bits and pad bits meet within a single read.

// File: rtl/zp_io_port_pkg.sv
`timescale 1ns/1ps
package zp_io_port_pkg;
  // which of the port registers the current address hits
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_DIR  = 2'd1,
    HIT_LAT  = 2'd2
  } port_hit_e;
endpackage

// File: rtl/zp_rst_sync.sv
`timescale 1ns/1ps
module zp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/zp_pin_sync.sv
`timescale 1ns/1ps
module zp_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_s
);
  logic [WIDTH-1:0] stg_q [STAGES];

  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      logic [WIDTH-1:0] stg_d;
      if (k == 0) begin : g_first
        always_comb stg_d = pin_i;
      end else begin : g_next
        always_comb stg_d = stg_q[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[k] <= '0;
        else        stg_q[k] <= stg_d;
      end
    end
  endgenerate

  assign pin_s = stg_q[STAGES-1];

  // checker: one-cycle warm-up so $past never reaches into reset
  logic warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 1'b0;
    else        warm_q <= 1'b1;
  end

  generate
    for (k = 0; k < STAGES; k++) begin : g_chk
      if (k == 0) begin : g_c0
        // R6
        sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
          warm_q |-> stg_q[0] == $past(pin_i));
      end else begin : g_cn
        // R6
        sync_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
          warm_q |-> stg_q[k] == $past(stg_q[k-1]));
      end
    end
  endgenerate
endmodule

// File: rtl/zp_decode.sv
`timescale 1ns/1ps
module zp_decode
  import zp_io_port_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DIR_ADDR = 0,
  parameter int unsigned LAT_ADDR = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rnw_i,
  output port_hit_e         hit_o,
  output logic              wr_dir_o,
  output logic              wr_lat_o
);
  localparam logic [ADDR_W-1:0] DIR_A = DIR_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] LAT_A = LAT_ADDR[ADDR_W-1:0];

  always_comb begin
    if (addr_i == DIR_A)      hit_o = HIT_DIR;
    else if (addr_i == LAT_A) hit_o = HIT_LAT;
    else                      hit_o = HIT_NONE;
    wr_dir_o = !rnw_i && (hit_o == HIT_DIR);
    wr_lat_o = !rnw_i && (hit_o == HIT_LAT);
  end
endmodule

// File: rtl/zp_regs.sv
`timescale 1ns/1ps
module zp_regs #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir_i,
  input  logic             wr_lat_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lat_q
);
  logic [WIDTH-1:0] dir_d;
  logic [WIDTH-1:0] lat_d;

  always_comb begin
    dir_d = dir_q;
    lat_d = lat_q;
    if (wr_dir_i) dir_d = wdata_i;
    if (wr_lat_i) lat_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lat_q <= '0;
    end else begin
      if (wr_dir_i) dir_q <= dir_d;
      if (wr_lat_i) lat_q <= lat_d;
    end
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir_i |=> dir_q == $past(wdata_i));
  // R8
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir_i |=> $stable(dir_q));
  // R3
  lat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lat_i |=> lat_q == $past(wdata_i));
  // R9
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lat_i |=> $stable(lat_q));
endmodule

// File: rtl/zp_rd_mux.sv
`timescale 1ns/1ps
module zp_rd_mux
  import zp_io_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  port_hit_e        hit_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] lat_i,
  input  logic [WIDTH-1:0] pin_s_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] merged;

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      assign merged[b] = dir_i[b] ? lat_i[b] : pin_s_i[b];
    end
  endgenerate

  always_comb begin
    unique case (hit_i)
      HIT_DIR: rdata_o = dir_i;
      HIT_LAT: rdata_o = merged;
      default: rdata_o = '0;
    endcase
  end

  // R5
  mix_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i == HIT_LAT) |-> ((rdata_o ^ lat_i) & dir_i) == '0);
  // R5
  mix_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i == HIT_LAT) |-> ((rdata_o ^ pin_s_i) & ~dir_i) == '0);
endmodule

// File: rtl/zp_io_port.sv
`timescale 1ns/1ps
module zp_io_port
  import zp_io_port_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DIR_ADDR    = 0,
  parameter int unsigned LAT_ADDR    = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [PORT_W-1:0] cpu_wdata,
  input  logic              cpu_rnw,
  output logic [PORT_W-1:0] cpu_rdata,
  output logic              port_sel,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  input  logic [PORT_W-1:0] pad_in
);
  logic              rst_n_i;
  port_hit_e         hit;
  logic              wr_dir;
  logic              wr_lat;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] lat_q;
  logic [PORT_W-1:0] pin_s;

  zp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_i)
  );

  zp_pin_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n_i), .pin_i(pad_in), .pin_s(pin_s)
  );

  zp_decode #(.ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .LAT_ADDR(LAT_ADDR)) u_dec (
    .addr_i(cpu_addr), .rnw_i(cpu_rnw), .hit_o(hit),
    .wr_dir_o(wr_dir), .wr_lat_o(wr_lat)
  );

  zp_regs #(.WIDTH(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .wr_dir_i(wr_dir), .wr_lat_i(wr_lat),
    .wdata_i(cpu_wdata), .dir_q(dir_q), .lat_q(lat_q)
  );

  zp_rd_mux #(.WIDTH(PORT_W)) u_mux (
    .clk(clk), .rst_n(rst_n_i), .hit_i(hit), .dir_i(dir_q),
    .lat_i(lat_q), .pin_s_i(pin_s), .rdata_o(cpu_rdata)
  );

  assign port_sel = (hit != HIT_NONE);
  assign pad_out  = lat_q;
  assign pad_oe   = dir_q;

  // R7
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !port_sel |-> cpu_rdata == '0);
  // R4
  dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cpu_addr == DIR_ADDR[ADDR_W-1:0]) |-> cpu_rdata == pad_oe);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n_i |-> (pad_oe == '0 && pad_out == '0));
endmodule

// File: tb/zp_io_port_tb.sv
`timescale 1ns/1ps
module zp_io_port_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_rnw;
  logic [7:0]  cpu_rdata;
  logic        port_sel;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;
  logic [7:0]  pad_in;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  zp_io_port u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rnw(cpu_rnw), .cpu_rdata(cpu_rdata), .port_sel(port_sel),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
  );

  typedef struct packed {
    logic [47:0] tag;
    logic [15:0] addr;
    logic        rnw;
    logic [7:0]  wdata;
    logic [7:0]  pin;
    logic [7:0]  exp_rd;
    logic        exp_sel;
    logic [7:0]  exp_oe;
    logic [7:0]  exp_out;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{"R1 R4 ", 16'h0000, 1'b1, 8'h00, 8'hA5, 8'h00, 1'b1, 8'h00, 8'h00},
    '{"R5    ", 16'h0001, 1'b1, 8'h00, 8'hA5, 8'hA5, 1'b1, 8'h00, 8'h00},
    '{"R2    ", 16'h0000, 1'b0, 8'hF0, 8'hA5, 8'hF0, 1'b1, 8'hF0, 8'h00},
    '{"R3 R5 ", 16'h0001, 1'b0, 8'h3C, 8'hA5, 8'h35, 1'b1, 8'hF0, 8'h3C},
    '{"R5    ", 16'h0001, 1'b1, 8'h00, 8'h5A, 8'h3A, 1'b1, 8'hF0, 8'h3C},
    '{"R8    ", 16'h0101, 1'b0, 8'hFF, 8'h5A, 8'h00, 1'b0, 8'hF0, 8'h3C},
    '{"R8    ", 16'hFF00, 1'b0, 8'h00, 8'h5A, 8'h00, 1'b0, 8'hF0, 8'h3C},
    '{"R4 R8 ", 16'h0000, 1'b1, 8'h00, 8'h5A, 8'hF0, 1'b1, 8'hF0, 8'h3C},
    '{"R7    ", 16'h0002, 1'b1, 8'h00, 8'h5A, 8'h00, 1'b0, 8'hF0, 8'h3C},
    '{"R2 R10", 16'h0000, 1'b0, 8'h0F, 8'h5A, 8'h0F, 1'b1, 8'h0F, 8'h3C},
    '{"R10   ", 16'h0001, 1'b1, 8'h00, 8'h5A, 8'h5C, 1'b1, 8'h0F, 8'h3C},
    '{"R9    ", 16'h0001, 1'b1, 8'hFF, 8'h5A, 8'h5C, 1'b1, 8'h0F, 8'h3C},
    '{"R7    ", 16'h8001, 1'b1, 8'h00, 8'h5A, 8'h00, 1'b0, 8'h0F, 8'h3C}
  };

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    rst_n     = 1'b0;
    cpu_addr  = 16'h0200;
    cpu_wdata = 8'h00;
    cpu_rnw   = 1'b1;
    pad_in    = 8'h00;
    repeat (3) @(posedge clk);
    // R1: state while reset held
    @(negedge clk);
    check("R1", "pad_oe in reset", pad_oe, 8'h00);
    check("R1", "pad_out in reset", pad_out, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string t;
      t = $sformatf("%s", TBL[i].tag);
      cpu_addr  = TBL[i].addr;
      cpu_rnw   = TBL[i].rnw;
      cpu_wdata = TBL[i].wdata;
      pad_in    = TBL[i].pin;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(t, "cpu_rdata", cpu_rdata, TBL[i].exp_rd);
      check(t, "port_sel", {7'd0, port_sel}, {7'd0, TBL[i].exp_sel});
      check(t, "pad_oe", pad_oe, TBL[i].exp_oe);
      check(t, "pad_out", pad_out, TBL[i].exp_out);
    end

    // R7: select on a write cycle to 0x0001 too (not clocked yet)
    cpu_addr = 16'h0001; cpu_rnw = 1'b0; cpu_wdata = 8'h3C;
    #1;
    check("R7", "port_sel write cycle", {7'd0, port_sel}, 8'h01);
    @(posedge clk);
    @(negedge clk);

    // R6: latency, mask 0x0F so upper nibble are inputs
    cpu_addr = 16'h0001; cpu_rnw = 1'b1;
    pad_in = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6", "settled", cpu_rdata, 8'h0C);
    pad_in = 8'hF0;
    @(posedge clk);
    @(negedge clk);
    check("R6", "after one edge", cpu_rdata, 8'h0C);
    @(posedge clk);
    @(negedge clk);
    check("R6", "after two edges", cpu_rdata, 8'hFC);

    // R5: all outputs, pads ignored
    cpu_addr = 16'h0000; cpu_rnw = 1'b0; cpu_wdata = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    cpu_addr = 16'h0001; cpu_rnw = 1'b1; pad_in = 8'hAA;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5", "all output read", cpu_rdata, 8'h3C);

    // R1: asynchronous reset mid-run clears both registers
    rst_n = 1'b0;
    #1;
    check("R1", "pad_oe after async reset", pad_oe, 8'h00);
    check("R1", "pad_out after async reset", pad_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    cpu_addr = 16'h0000;
    #1;
    check("R1", "dir after release", cpu_rdata, 8'h00);

    done = 1'b1;
    summary();
  end
endmodule